// File: doc/BRIEF.md
# Tiled Soft-Value Matrix Store with Two-Lane Dispatch

This block holds a matrix of soft values, one small symbol per cell, for a decoder that alternates between row passes and column passes. Each memory word carries a 2×2 tile: two neighbouring rows crossed with two neighbouring columns. One access per clock therefore moves four symbols through a plain single-port array. Both matrix dimensions must be even. The default matrix is 32×32 with 5-bit symbols, so the array has 256 words of 20 bits.

The four symbols of a tile are split into two lanes of two symbols each, one lane per downstream decoder. The split follows the pass direction. In a row pass, each lane carries two neighbours from the same row. In a column pass, each lane carries two neighbours from the same column. Writes go through the same split as reads, so results come back in the form in which they were read.

A built-in tile counter walks the matrix in either order, so a pass can be driven with nothing more than a step strobe. A select input chooses whether an access uses the counter's position or an explicit tile address.

Top module: `tile_dispatch`

## Requirements
- R1: Tile (I, J), with both coordinates 0-based, holds the symbols in rows 2I and 2I+1 and columns 2J and 2J+1 in one word. Any symbol written in one pass direction reads back unchanged in the other.
- R2: In row mode (colMode=0), a read gives rdLaneA = {sym(2I,2J+1), sym(2I,2J)} and rdLaneB = {sym(2I+1,2J+1), sym(2I+1,2J)}. The low 5 bits of each lane hold the lower column.
- R3: In column mode (colMode=1), a read gives rdLaneA = {sym(2I+1,2J), sym(2I,2J)} and rdLaneB = {sym(2I+1,2J+1), sym(2I,2J+1)}. The low 5 bits of each lane hold the lower row.
- R4: A write applies the same lane-to-symbol mapping as a read in the current mode, and all four symbols of the tile are written at once.
- R5: Read data and rdValid appear on the clock after the cycle in which rdEn is high. rdValid is high for exactly that one cycle.
- R6: When wrEn and rdEn are high together, the write is done and the read is dropped. rdValid stays low and the read lanes keep their previous values.
- R7: The read lanes hold their last values in every cycle that follows a cycle without an accepted read.
- R8: In row mode, each sweepStep moves the counter to the next column tile. After the last column tile it goes to column 0 of the next row tile.
- R9: In column mode, each sweepStep moves the counter to the next row tile. After the last row tile it goes to row 0 of the next column tile.
- R10: seqLast is high exactly when the counter is at the final tile (both coordinates at their maximum). A step from the final tile returns the counter to (0,0). sweepStart sets (0,0) and takes priority over sweepStep.
- R11: While rstN is low and right after reset, rdValid is 0, both read lanes are 0 and the counter is at (0,0).
- R12: With seqSel=1, an access uses the counter position of that cycle, and a step in the same cycle takes effect afterwards. With seqSel=0, it uses tileRow and tileCol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| colMode | input | 1 | Pass direction: 0 row, 1 column |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe, wins over rdEn |
| seqSel | input | 1 | 1: address from counter, 0: from tileRow/tileCol |
| tileRow | input | 4 | Explicit tile row I |
| tileCol | input | 4 | Explicit tile column J |
| wrLaneA | input | 10 | Write lane for decoder one |
| wrLaneB | input | 10 | Write lane for decoder two |
| sweepStart | input | 1 | Reset counter to tile (0,0) |
| sweepStep | input | 1 | Advance counter in current order |
| rdLaneA | output | 10 | Read lane for decoder one |
| rdLaneB | output | 10 | Read lane for decoder two |
| rdValid | output | 1 | Read lanes updated this cycle |
| seqRow | output | 4 | Counter tile row |
| seqCol | output | 4 | Counter tile column |
| seqLast | output | 1 | Counter at final tile |

## Verification
The whole matrix is filled by a row-order sweep and then read back by a column-order sweep. Because every stored symbol is random, any wrong lane mapping or wrong tile address shows up as a miscompare. This also tells a transposed write apart from a correct one. Tiles written in column mode are then read in row mode at explicit corner and interior addresses, which separates the two halves of the mapping. Collisions of read and write, idle cycles, sweep restarts while stepping, and wrapping from the final tile check that the lanes hold, that reads are dropped correctly and that the counter orders are right.

// File: rtl/tile_pkg.sv
package tile_pkg;
  typedef struct packed {
    logic wr;
    logic rd;
    logic colMode;
  } tile_strobe_t;
endpackage

// File: rtl/tile_ctrl.sv
module tile_ctrl
  import tile_pkg::*;
#(
  parameter int TILE_ROWS = 16,
  parameter int TILE_COLS = 16,
  parameter int TR_W = (TILE_ROWS > 1) ? $clog2(TILE_ROWS) : 1,
  parameter int TC_W = (TILE_COLS > 1) ? $clog2(TILE_COLS) : 1,
  parameter int ADDR_W = ((TILE_ROWS * TILE_COLS) > 1) ? $clog2(TILE_ROWS * TILE_COLS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              colMode,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              seqSel,
  input  logic [TR_W-1:0]   tileRow,
  input  logic [TC_W-1:0]   tileCol,
  input  logic              sweepStart,
  input  logic              sweepStep,
  output tile_strobe_t      strobe,
  output logic [ADDR_W-1:0] addr,
  output logic [TR_W-1:0]   seqRow,
  output logic [TC_W-1:0]   seqCol,
  output logic              seqLast
);
  localparam logic [TR_W-1:0] ROW_MAX = TR_W'(TILE_ROWS - 1);
  localparam logic [TC_W-1:0] COL_MAX = TC_W'(TILE_COLS - 1);

  logic rowAtMax, colAtMax;
  logic [TR_W-1:0] selRow;
  logic [TC_W-1:0] selCol;

  assign rowAtMax = (seqRow == ROW_MAX);
  assign colAtMax = (seqCol == COL_MAX);
  assign seqLast  = rowAtMax && colAtMax;

  always_ff @(posedge clk) begin
    if (!rstN || sweepStart) begin
      seqRow <= '0;
      seqCol <= '0;
    end else if (sweepStep) begin
      if (!colMode) begin
        if (colAtMax) begin
          seqCol <= '0;
          seqRow <= rowAtMax ? '0 : seqRow + TR_W'(1);
        end else begin
          seqCol <= seqCol + TC_W'(1);
        end
      end else begin
        if (rowAtMax) begin
          seqRow <= '0;
          seqCol <= colAtMax ? '0 : seqCol + TC_W'(1);
        end else begin
          seqRow <= seqRow + TR_W'(1);
        end
      end
    end
  end

  always_comb begin
    selRow = seqSel ? seqRow : tileRow;
    selCol = seqSel ? seqCol : tileCol;
    addr   = ADDR_W'(selRow) * ADDR_W'(TILE_COLS) + ADDR_W'(selCol);
    strobe.wr      = wrEn;
    strobe.rd      = rdEn && !wrEn;
    strobe.colMode = colMode;
  end

  // R8
  row_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sweepStep && !sweepStart && !colMode && !colAtMax)
      |=> (seqCol == $past(seqCol) + TC_W'(1)) && $stable(seqRow));

  // R9
  col_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sweepStep && !sweepStart && colMode && !rowAtMax)
      |=> (seqRow == $past(seqRow) + TR_W'(1)) && $stable(seqCol));

  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqLast && sweepStep) |=> (seqRow == '0) && (seqCol == '0));

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    sweepStart |=> (seqRow == '0) && (seqCol == '0) && !seqLast);
endmodule

// File: rtl/tile_datapath.sv
module tile_datapath
  import tile_pkg::*;
#(
  parameter int SYM_W  = 5,
  parameter int WORDS  = 256,
  parameter int ADDR_W = 8,
  parameter int LANE_W = 2 * SYM_W,
  parameter int WORD_W = 4 * SYM_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tile_strobe_t      strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wrLaneA,
  input  logic [LANE_W-1:0] wrLaneB,
  output logic [LANE_W-1:0] rdLaneA,
  output logic [LANE_W-1:0] rdLaneB,
  output logic              rdValid
);
  // word symbol order, low to high: top-left, top-right, bottom-left, bottom-right
  logic [WORD_W-1:0] mem [WORDS];
  logic [WORD_W-1:0] wrWord, rdWordQ;
  logic              modeQ;
  logic [SYM_W-1:0]  tl, tr, bl, br;

  always_comb begin
    if (!strobe.colMode)
      wrWord = {wrLaneB, wrLaneA};
    else
      wrWord = {wrLaneB[LANE_W-1:SYM_W], wrLaneA[LANE_W-1:SYM_W],
                wrLaneB[SYM_W-1:0], wrLaneA[SYM_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (strobe.wr) mem[addr] <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdWordQ <= '0;
      modeQ   <= 1'b0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.rd;
      if (strobe.rd) begin
        rdWordQ <= mem[addr];
        modeQ   <= strobe.colMode;
      end
    end
  end

  always_comb begin
    {br, bl, tr, tl} = rdWordQ;
    if (!modeQ) begin
      rdLaneA = {tr, tl};
      rdLaneB = {br, bl};
    end else begin
      rdLaneA = {bl, tl};
      rdLaneB = {br, tr};
    end
  end

  // R6
  collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wr) |=> !rdValid);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> ($stable(rdLaneA) && $stable(rdLaneB)));
endmodule

// File: rtl/tile_dispatch.sv
module tile_dispatch
  import tile_pkg::*;
#(
  parameter int SYM_W  = 5,
  parameter int N_ROWS = 32,
  parameter int N_COLS = 32,
  parameter int TILE_ROWS = N_ROWS / 2,
  parameter int TILE_COLS = N_COLS / 2,
  parameter int TR_W = (TILE_ROWS > 1) ? $clog2(TILE_ROWS) : 1,
  parameter int TC_W = (TILE_COLS > 1) ? $clog2(TILE_COLS) : 1,
  parameter int LANE_W = 2 * SYM_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              colMode,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              seqSel,
  input  logic [TR_W-1:0]   tileRow,
  input  logic [TC_W-1:0]   tileCol,
  input  logic [LANE_W-1:0] wrLaneA,
  input  logic [LANE_W-1:0] wrLaneB,
  input  logic              sweepStart,
  input  logic              sweepStep,
  output logic [LANE_W-1:0] rdLaneA,
  output logic [LANE_W-1:0] rdLaneB,
  output logic              rdValid,
  output logic [TR_W-1:0]   seqRow,
  output logic [TC_W-1:0]   seqCol,
  output logic              seqLast
);
  localparam int WORDS  = TILE_ROWS * TILE_COLS;
  localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  tile_strobe_t      strobe;
  logic [ADDR_W-1:0] addr;

  tile_ctrl #(
    .TILE_ROWS(TILE_ROWS), .TILE_COLS(TILE_COLS),
    .TR_W(TR_W), .TC_W(TC_W), .ADDR_W(ADDR_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .colMode(colMode), .rdEn(rdEn), .wrEn(wrEn),
    .seqSel(seqSel), .tileRow(tileRow), .tileCol(tileCol),
    .sweepStart(sweepStart), .sweepStep(sweepStep),
    .strobe(strobe), .addr(addr),
    .seqRow(seqRow), .seqCol(seqCol), .seqLast(seqLast)
  );

  tile_datapath #(
    .SYM_W(SYM_W), .WORDS(WORDS), .ADDR_W(ADDR_W)
  ) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr),
    .wrLaneA(wrLaneA), .wrLaneB(wrLaneB),
    .rdLaneA(rdLaneA), .rdLaneB(rdLaneB), .rdValid(rdValid)
  );

  // R5
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn) |=> rdValid);

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);
endmodule

// File: tb/tile_dispatch_test.sv
module tile_dispatch_test;
  logic clk = 1'b0;
  logic rstN;
  logic colMode, rdEn, wrEn, seqSel, sweepStart, sweepStep;
  logic [3:0] tileRow, tileCol;
  logic [9:0] wrLaneA, wrLaneB, rdLaneA, rdLaneB;
  logic rdValid, seqLast;
  logic [3:0] seqRow, seqCol;

  int vectors = 0;
  int fails = 0;
  int m [32][32];
  int expRow = 0, expCol = 0;
  bit expValid = 0;
  logic [9:0] expA = '0, expB = '0;
  string phase = "R11";

  always #2 clk = ~clk;

  tile_dispatch uut (
    .clk(clk), .rstN(rstN), .colMode(colMode), .rdEn(rdEn), .wrEn(wrEn),
    .seqSel(seqSel), .tileRow(tileRow), .tileCol(tileCol),
    .wrLaneA(wrLaneA), .wrLaneB(wrLaneB),
    .sweepStart(sweepStart), .sweepStep(sweepStep),
    .rdLaneA(rdLaneA), .rdLaneB(rdLaneB), .rdValid(rdValid),
    .seqRow(seqRow), .seqCol(seqCol), .seqLast(seqLast)
  );

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check("rdValid", 32'(rdValid), 32'(expValid));
    check("rdLaneA", 32'(rdLaneA), 32'(expA));
    check("rdLaneB", 32'(rdLaneB), 32'(expB));
    check("seqRow", 32'(seqRow), 32'(expRow));
    check("seqCol", 32'(seqCol), 32'(expCol));
    check("seqLast", 32'(seqLast), 32'(expRow == 15 && expCol == 15));
  endtask

  task automatic apply(bit cm, bit rd, bit wr, bit sel, bit st, bit stp,
                       int tr, int tc, logic [9:0] wa, logic [9:0] wb);
    int ti, tj, i, j;
    colMode = cm; rdEn = rd; wrEn = wr; seqSel = sel;
    sweepStart = st; sweepStep = stp;
    tileRow = 4'(tr); tileCol = 4'(tc); wrLaneA = wa; wrLaneB = wb;
    ti = sel ? expRow : tr;
    tj = sel ? expCol : tc;
    i = 2 * ti; j = 2 * tj;
    if (wr) begin
      m[i][j] = int'(wa[4:0]);
      m[i+1][j+1] = int'(wb[9:5]);
      if (!cm) begin
        m[i][j+1] = int'(wa[9:5]); m[i+1][j] = int'(wb[4:0]);
      end else begin
        m[i+1][j] = int'(wa[9:5]); m[i][j+1] = int'(wb[4:0]);
      end
      expValid = 0;
    end else if (rd) begin
      expValid = 1;
      if (!cm) begin
        expA = {5'(m[i][j+1]), 5'(m[i][j])};
        expB = {5'(m[i+1][j+1]), 5'(m[i+1][j])};
      end else begin
        expA = {5'(m[i+1][j]), 5'(m[i][j])};
        expB = {5'(m[i+1][j+1]), 5'(m[i][j+1])};
      end
    end else begin
      expValid = 0;
    end
    if (st) begin
      expRow = 0; expCol = 0;
    end else if (stp) begin
      if (!cm) begin
        if (expCol == 15) begin expCol = 0; expRow = (expRow == 15) ? 0 : expRow + 1; end
        else expCol++;
      end else begin
        if (expRow == 15) begin expRow = 0; expCol = (expCol == 15) ? 0 : expCol + 1; end
        else expRow++;
      end
    end
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(bit cm);
    apply(cm, 0, 0, 0, 0, 0, 0, 0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    foreach (m[a, b]) m[a][b] = 0;
    rstN = 0;
    colMode = 0; rdEn = 0; wrEn = 0; seqSel = 0; sweepStart = 0; sweepStep = 0;
    tileRow = '0; tileCol = '0; wrLaneA = '0; wrLaneB = '0;
    repeat (3) @(negedge clk);
    // R11: reset values
    compareAll();
    rstN = 1;
    idle(0);

    // R8 R4 R12: fill the matrix by a row-order sweep with row-mode writes
    phase = "R8";
    apply(0, 0, 0, 0, 1, 0, 0, 0, '0, '0);
    for (int k = 0; k < 256; k++)
      apply(0, 0, 1, 1, 0, 1, 0, 0, 10'($urandom), 10'($urandom));
    // R10: the counter has wrapped back to (0,0)
    phase = "R10";
    idle(0);

    // R9 R3 R1: read everything back by a column-order sweep
    phase = "R9";
    apply(1, 0, 0, 0, 1, 0, 0, 0, '0, '0);
    for (int k = 0; k < 256; k++)
      apply(1, 1, 0, 1, 0, 1, 0, 0, '0, '0);
    // R7: lanes hold through idle cycles
    phase = "R7";
    idle(1); idle(0); idle(1);

    // R2: explicit row-mode reads at corners and interior tiles
    phase = "R2";
    apply(0, 1, 0, 0, 0, 0, 0, 0, '0, '0);
    apply(0, 1, 0, 0, 0, 0, 15, 15, '0, '0);
    apply(0, 1, 0, 0, 0, 0, 3, 9, '0, '0);
    apply(0, 1, 0, 0, 0, 0, 15, 0, '0, '0);
    idle(0);

    // R4 R1: column-mode writes read back in row mode and column mode
    phase = "R4";
    apply(1, 0, 1, 0, 0, 0, 5, 7, 10'h3a5, 10'h1c3);
    apply(1, 0, 1, 0, 0, 0, 0, 15, 10'h2f0, 10'h00f);
    apply(0, 1, 0, 0, 0, 0, 5, 7, '0, '0);
    apply(1, 1, 0, 0, 0, 0, 5, 7, '0, '0);
    apply(0, 1, 0, 0, 0, 0, 0, 15, '0, '0);

    // R6: simultaneous read and write, write wins and lanes hold
    phase = "R6";
    apply(0, 1, 1, 0, 0, 0, 5, 7, 10'h155, 10'h2aa);
    idle(0);
    apply(0, 1, 0, 0, 0, 0, 5, 7, '0, '0);

    // R10 R9: restart wins over step, mid-sweep column order, wrap from last
    phase = "R10";
    apply(1, 0, 0, 0, 0, 1, 0, 0, '0, '0);
    apply(1, 0, 0, 0, 1, 1, 0, 0, '0, '0);
    for (int k = 0; k < 20; k++) apply(1, 0, 0, 0, 0, 1, 0, 0, '0, '0);
    for (int k = 0; k < 236; k++) apply(1, 0, 0, 0, 0, 1, 0, 0, '0, '0);
    apply(1, 0, 0, 0, 0, 1, 0, 0, '0, '0);

    // R12: explicit address ignores the counter, counter address ignores tileRow
    phase = "R12";
    apply(0, 1, 0, 1, 0, 0, 9, 9, '0, '0);
    apply(0, 1, 0, 0, 0, 0, 9, 9, '0, '0);
    idle(0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule